// File: doc/BRIEF.md
# Logical and Arithmetic Barrel Shifter

This block is a purely combinational word shifter for an integer datapath. In one pass it moves a data word left with zero fill, right with zero fill, or right with copies of the sign bit. The arithmetic right shift acts as signed division of a two's-complement value by a power of two, rounding toward minus infinity.

The shift distance comes from one of two places, chosen by a mode input. The first is a small constant field taken from the instruction. The second is a full-width register operand, of which only the low bits that can address a bit position are used. The result settles in the same cycle as the inputs. A pipeline that wants the result registered keeps its own register in front of or behind the shifter.

The core is a logarithmic cascade. Each stage moves the word by a fixed power-of-two distance, and one bit of the selected amount turns that stage on or off.

Top module: `barrel_shifter`

## Requirements
- R1: With kind code 2'b00 (left), the result is the data moved toward the MSB by the amount, with zeros in the vacated low positions; 0x0000000D by 8 gives 0x00000D00.
- R2: With kind code 2'b01 (logical right), the result is the data moved toward the LSB, with zeros in the vacated high positions; 0xFFFFFFF0 by 2 gives 0x3FFFFFFC.
- R3: With kind code 2'b10 (arithmetic right), the vacated high positions take the data's bit 31. 0xFFFFFFF0 by 2 gives 0xFFFFFFFC, and a positive word is zero-filled.
- R4: With var_mode_i = 1, the amount is taken from reg_amt_i[4:0]; -128 (0xFFFFFF80) shifted arithmetically right by a register value of 4 gives -8 (0xFFFFFFF8).
- R5: With var_mode_i = 1, bits 31..5 of reg_amt_i have no effect on the result.
- R6: An amount of 0 returns the data unchanged for every kind.
- R7: With var_mode_i = 0, the amount is imm_amt_i, and reg_amt_i has no effect on the result.
- R8: Kind code 2'b11 behaves exactly as logical right.
- R9: The largest amount, 31, leaves only one data bit in place (left and logical right), or a word filled entirely with the sign (arithmetic right).
- R10: A left shift by 22 followed by a logical right shift by 24 moves bits 9..2 of the original word into bits 7..0, with all higher bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 32 | Word to be shifted |
| imm_amt_i | input | 5 | Constant shift distance |
| reg_amt_i | input | 32 | Register operand supplying the distance in variable mode |
| kind_i | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 logical right |
| var_mode_i | input | 1 | 1 selects reg_amt_i[4:0] as the distance, 0 selects imm_amt_i |
| result_o | output | 32 | Shifted word |

## Verification
The hardest case to reach from the ports is the one where the unused upper bits of the register amount would change the result if they leaked into the cascade. That only shows up when those bits are non-zero and the low five bits are not. The stimulus therefore pairs register amounts whose upper bits are all ones or a mixed pattern with every distance from 0 to 31, for all four kind codes. It also repeats each immediate-mode case with a busy register operand, and it chains two shifts to check the field-extraction idiom end to end.

// File: rtl/shift_pkg.sv
package shift_pkg;

   // Shift kind encoding; the low bit alone does not decide direction.
   typedef enum logic [1:0] {
      SH_LEFT      = 2'b00,
      SH_RIGHT_LOG = 2'b01,
      SH_RIGHT_ARI = 2'b10,
      SH_RIGHT_ALT = 2'b11
   } shift_kind_e;

endpackage

// File: rtl/shift_amt_select.sv
module shift_amt_select #(
   parameter int DATA_W = 32,
   parameter int AMT_W  = $clog2(DATA_W)
) (
   input  logic [AMT_W-1:0]  imm_amt_i,
   input  logic [DATA_W-1:0] reg_amt_i,
   input  logic              var_mode_i,
   output logic [AMT_W-1:0]  amt_o
);

   // Upper register bits cannot name a bit position; they are discarded.
   logic unused_reg_hi;
   assign unused_reg_hi = ^reg_amt_i[DATA_W-1:AMT_W];

   always_comb begin
      if (var_mode_i) amt_o = reg_amt_i[AMT_W-1:0];
      else            amt_o = imm_amt_i;
   end

endmodule

// File: rtl/shift_stage.sv
module shift_stage #(
   parameter int DATA_W = 32,
   parameter int DIST   = 1
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic              en_i,
   input  logic              left_i,
   input  logic              fill_i,
   output logic [DATA_W-1:0] data_o
);

   logic [DATA_W-1:0] moved_left;
   logic [DATA_W-1:0] moved_right;

   assign moved_left  = {data_i[DATA_W-1-DIST:0], {DIST{1'b0}}};
   assign moved_right = {{DIST{fill_i}}, data_i[DATA_W-1:DIST]};

   always_comb begin
      if (!en_i)       data_o = data_i;
      else if (left_i) data_o = moved_left;
      else             data_o = moved_right;
   end

endmodule

// File: rtl/barrel_shifter.sv
module barrel_shifter
   import shift_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int AMT_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [AMT_W-1:0]  imm_amt_i,
   input  logic [DATA_W-1:0] reg_amt_i,
   input  logic [1:0]        kind_i,
   input  logic              var_mode_i,
   output logic [DATA_W-1:0] result_o
);

   generate
      if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("barrel_shifter: DATA_W must be a power of two of at least 2");
      end
   endgenerate

   shift_kind_e       kind;
   logic [AMT_W-1:0]  amt;
   logic              go_left;
   logic              fill_bit;
   logic [DATA_W-1:0] stage_q [AMT_W+1];

   assign kind     = shift_kind_e'(kind_i);
   assign go_left  = (kind == SH_LEFT);
   assign fill_bit = (kind == SH_RIGHT_ARI) & data_i[DATA_W-1];

   shift_amt_select #(
      .DATA_W (DATA_W),
      .AMT_W  (AMT_W)
   ) u_amt (
      .imm_amt_i  (imm_amt_i),
      .reg_amt_i  (reg_amt_i),
      .var_mode_i (var_mode_i),
      .amt_o      (amt)
   );

   assign stage_q[0] = data_i;

   generate
      for (genvar s = 0; s < AMT_W; s++) begin : g_stage
         shift_stage #(
            .DATA_W (DATA_W),
            .DIST   (1 << s)
         ) u_stage (
            .data_i (stage_q[s]),
            .en_i   (amt[s]),
            .left_i (go_left),
            .fill_i (fill_bit),
            .data_o (stage_q[s+1])
         );
      end
   endgenerate

   assign result_o = stage_q[AMT_W];

endmodule

// File: rtl/barrel_shifter_chk.sv
module barrel_shifter_chk #(
   parameter int DATA_W = 32,
   localparam int AMT_W = $clog2(DATA_W)
) (
   input logic [DATA_W-1:0] data_i,
   input logic [AMT_W-1:0]  imm_amt_i,
   input logic [DATA_W-1:0] reg_amt_i,
   input logic [1:0]        kind_i,
   input logic              var_mode_i,
   input logic [DATA_W-1:0] result_o
);

   logic [AMT_W-1:0]  eff;
   logic [DATA_W-1:0] low_mask;
   logic [DATA_W-1:0] high_mask;

   assign eff       = var_mode_i ? reg_amt_i[AMT_W-1:0] : imm_amt_i;
   assign low_mask  = ~({DATA_W{1'b1}} << eff);
   assign high_mask = ~({DATA_W{1'b1}} >> eff);

   always_comb begin
      if (kind_i == 2'b00)
         p_left_zero_fill_r1: assert ((result_o & low_mask) == '0)
            else $error("left shift put ones into vacated low bits");
      if (kind_i == 2'b01 || kind_i == 2'b11)
         p_right_zero_fill_r2: assert ((result_o & high_mask) == '0)
            else $error("logical right shift put ones into vacated high bits");
      if (kind_i == 2'b10)
         p_sign_fill_r3: assert ((result_o & high_mask) ==
                                 (data_i[DATA_W-1] ? high_mask : '0))
            else $error("arithmetic right shift lost the sign");
      if (eff == '0)
         p_zero_pass_r6: assert (result_o == data_i)
            else $error("zero distance altered the word");
      if (kind_i == 2'b10 && eff == AMT_W'(DATA_W - 1))
         p_full_sign_r9: assert (result_o == {DATA_W{data_i[DATA_W-1]}})
            else $error("maximum arithmetic shift is not pure sign");
   end

endmodule

bind barrel_shifter barrel_shifter_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_barrel_shifter.sv
module tb_barrel_shifter;

   localparam int NV = 13;

   localparam logic [31:0] V_DATA [NV] = '{
      32'h0000000D, 32'hFFFFFFF0, 32'hFFFFFFF0, 32'hFFFFFF80, 32'hFFFFFF80,
      32'h12345678, 32'h12345678, 32'h80000000, 32'h80000000, 32'h00000001,
      32'h7FFFFFF0, 32'hF0000000, 32'h0F0F0F0F};
   localparam logic [4:0] V_IMM [NV] = '{
      5'd8, 5'd2, 5'd2, 5'd0, 5'd0, 5'd0, 5'd0, 5'd31, 5'd31, 5'd31,
      5'd4, 5'd4, 5'd0};
   localparam logic [31:0] V_REG [NV] = '{
      32'h0, 32'hFFFFFFFF, 32'h0, 32'h4, 32'hFFFFFFE4, 32'h0, 32'hABCDEF00,
      32'h0, 32'h5, 32'h0, 32'h0, 32'hFFFFFFFF, 32'h3};
   localparam logic [1:0] V_KIND [NV] = '{
      2'b00, 2'b01, 2'b10, 2'b10, 2'b10, 2'b01, 2'b10, 2'b10, 2'b01, 2'b00,
      2'b10, 2'b11, 2'b00};
   localparam logic V_VAR [NV] = '{
      1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0,
      1'b0, 1'b0, 1'b1};
   localparam logic [31:0] V_EXP [NV] = '{
      32'h00000D00, 32'h3FFFFFFC, 32'hFFFFFFFC, 32'hFFFFFFF8, 32'hFFFFFFF8,
      32'h12345678, 32'h12345678, 32'hFFFFFFFF, 32'h00000001, 32'h80000000,
      32'h07FFFFFF, 32'h0F000000, 32'h78787878};

   function automatic string vec_tag(int i);
      case (i)
         0:       return "R1";
         1:       return "R2 R7";
         2, 10:   return "R3";
         3, 12:   return "R4";
         4:       return "R5";
         5, 6:    return "R6";
         11:      return "R7 R8";
         default: return "R9";
      endcase
   endfunction

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] data_i = '0;
   logic [4:0]  imm_amt_i = '0;
   logic [31:0] reg_amt_i = '0;
   logic [1:0]  kind_i = '0;
   logic        var_mode_i = 1'b0;
   logic [31:0] result_o;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   barrel_shifter dut (
      .data_i     (data_i),
      .imm_amt_i  (imm_amt_i),
      .reg_amt_i  (reg_amt_i),
      .kind_i     (kind_i),
      .var_mode_i (var_mode_i),
      .result_o   (result_o)
   );

   task automatic apply(input logic [31:0] d, input logic [4:0] im,
                        input logic [31:0] rg, input logic [1:0] k,
                        input logic vm);
      @(negedge clk);
      data_i = d; imm_amt_i = im; reg_amt_i = rg; kind_i = k; var_mode_i = vm;
      #2;
   endtask

   task automatic check(input string tag, input logic [31:0] exp);
      n_chk++;
      if (result_o !== exp) begin
         n_bad++;
         $display("FAIL %s: result %h, expected %h", tag, result_o, exp);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] mid, exp;
      repeat (2) @(posedge clk);
      rst = 1'b0;

      // Idle inputs: all-zero word stays zero (R6).
      apply(32'h0, 5'd0, 32'h0, 2'b00, 1'b0);
      check("R6 idle", 32'h0);

      for (int i = 0; i < NV; i++) begin
         apply(V_DATA[i], V_IMM[i], V_REG[i], V_KIND[i], V_VAR[i]);
         check(vec_tag(i), V_EXP[i]);
      end

      // R10: left 22 then logical right 24 extracts bits 9..2.
      apply(32'hABCDE7A5, 5'd22, 32'h0, 2'b00, 1'b0);
      mid = result_o;
      apply(mid, 5'd24, 32'h0, 2'b01, 1'b0);
      check("R10 extract", 32'h000000E9);

      // Sweep every distance and kind in both modes; busy upper register bits (R5, R7, R8).
      for (int k = 0; k < 4; k++) begin
         for (int a = 0; a < 32; a++) begin
            case (k)
               0:       exp = 32'h96A5C3E1 << a;
               2:       exp = 32'($signed(32'h96A5C3E1) >>> a);
               default: exp = 32'h96A5C3E1 >> a;
            endcase
            apply(32'h96A5C3E1, 5'(a), {27'h5A5A5A5, 5'(a)}, 2'(k), 1'b1);
            check("R5 R8 variable sweep", exp);
            apply(32'h96A5C3E1, 5'(a), {27'h7FFFFFF, ~5'(a)}, 2'(k), 1'b0);
            check("R7 R8 immediate sweep", exp);
         end
      end

      // R3: positive word zero-filled by arithmetic shift at max distance.
      apply(32'h7FFFFFFF, 5'd31, 32'h0, 2'b10, 1'b0);
      check("R3 R9 positive", 32'h0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule